// File: doc/BRIEF.md
# Page Write Commit Sequencer

This block sits behind the serial-bus decoder of a byte-addressed nonvolatile memory. It gathers the data bytes of one write transfer into a page buffer, where each byte sits at the in-page offset that came with it. When the transfer is closed by a STOP and holds at least one byte, the block starts a self-timed commit of fixed length. During the commit it drives write strobes into the memory array, one per buffered offset.

For the whole commit the block reports busy. It also refuses to acknowledge the device-address byte, so the bus master can poll with repeated address attempts until it gets an acknowledge. Bytes, STARTs and STOPs that arrive while busy have no effect. A write-protect input drops the buffered page at STOP so that no commit starts, and it also gates every array strobe. A START that arrives before the STOP of a write transfer throws away whatever was buffered.

The commit length is a parameter counted in system clocks. Its default stands for 5 ms at 100 MHz. It must be at least one page long, because the array strobes are issued during the first `PAGE_BYTES` cycles of the commit.

Top module: `page_commit_ctrl`

## Requirements
- R1: `busy_o` rises only in the cycle after a cycle in which `stop_evt_i` was high, at least one byte was buffered, `wp_i` was low and the block was not busy. A STOP with an empty buffer leaves `busy_o` low.
- R2: Once raised, `busy_o` stays high for exactly `WRITE_CYCLES` clock cycles and then falls by itself.
- R3: While `busy_o` is high, `addr_ack_o` is 0 even when `addr_hit_i` is 1. While busy, `byte_vld_i`, `start_evt_i` and `stop_evt_i` change no state.
- R4: While `busy_o` is low, `addr_ack_o` equals `addr_hit_i` in the same cycle (1 means acknowledge).
- R5: If `wp_i` is high when the STOP arrives, the buffered bytes are discarded, `busy_o` stays low and no `arr_we_o` pulse occurs. `arr_we_o` is never high while `wp_i` is high.
- R6: During a commit, `arr_we_o` pulses exactly once for each offset received in the transfer, in ascending offset order (0 to `PAGE_BYTES`-1), within the first `PAGE_BYTES` busy cycles. Each pulse carries the last data byte received for that offset and the row given with the last accepted byte. Offsets that were not received are not written.
- R7: A `start_evt_i` while not busy discards all buffered bytes, so a following STOP starts no commit.
- R8: After a commit the buffer is empty: a STOP with no new bytes starts no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_i | input | 1 | Write protect, high blocks all array writes |
| start_evt_i | input | 1 | One-cycle pulse: START seen on the bus |
| stop_evt_i | input | 1 | One-cycle pulse: STOP seen on the bus |
| addr_hit_i | input | 1 | Device-address byte matched, acknowledge wanted |
| addr_ack_o | output | 1 | Drive acknowledge for the device address |
| byte_vld_i | input | 1 | One-cycle pulse: a write data byte was received |
| byte_off_i | input | OFF_W | In-page offset of the received byte |
| byte_dat_i | input | 8 | Received data byte |
| byte_row_i | input | ROW_W | Page row of the received byte |
| busy_o | output | 1 | Internal write cycle in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_row_o | output | ROW_W | Array page row for the strobe |
| arr_off_o | output | OFF_W | Array in-page offset for the strobe |
| arr_dat_o | output | 8 | Array write data |

## Verification
The assertions assume that the decoder pulses bus events for one clock only, that it never raises START and STOP in the same cycle, and that it presents bytes only between a START and a STOP. They also assume a constant `wp_i` for the length of each transfer. The random stimulus builds every transfer from single-cycle pulses that are separated by idle cycles. It wraps offsets within the page to exercise repeated offsets, and it changes `wp_i` only between transfers. Inside these limits, it still drives bytes, START, STOP and address hits into the busy window on purpose, to test that they are ignored.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } slot_t;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_DISCARD,
        EV_COMMIT
    } stop_act_e;

    function automatic stop_act_e stop_action(input logic stop, input logic start,
                                              input logic busy, input logic pending,
                                              input logic wp);
        if (busy)
            return EV_NONE;
        if (start)
            return EV_DISCARD;
        if (stop && wp)
            return EV_DISCARD;
        if (stop && pending)
            return EV_COMMIT;
        return EV_NONE;
    endfunction

endpackage

// File: rtl/page_buf.sv
module page_buf
    import page_commit_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_dat,
    input  logic              clr,
    input  logic [OFF_W-1:0]  rd_off,
    output slot_t             rd_slot,
    output logic              any_vld
);

    slot_t slots [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                slots[i] <= '0;
        end else if (wr_en) begin
            slots[wr_off] <= '{vld: 1'b1, dat: wr_dat};
        end
    end

    always_comb begin
        any_vld = 1'b0;
        for (int i = 0; i < PAGE_BYTES; i++)
            any_vld = any_vld | slots[i].vld;
    end

    assign rd_slot = slots[rd_off];

    // R8: a clear leaves nothing pending in the next cycle
    assert_empty_after_clr_R8: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> !any_vld);

endmodule

// File: rtl/commit_seq.sv
module commit_seq #(
    parameter int PAGE_BYTES   = 64,
    parameter int WRITE_CYCLES = 500000,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int TMR_W = $clog2(WRITE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output logic             busy,
    output logic             done,
    output logic             scan_act,
    output logic [OFF_W-1:0] scan_off
);

    logic [TMR_W-1:0] tmr;
    logic             last;

    assign last     = busy && (tmr == TMR_W'(WRITE_CYCLES - 1));
    assign done     = last;
    assign scan_act = busy && (tmr < TMR_W'(PAGE_BYTES));
    assign scan_off = tmr[OFF_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            tmr  <= '0;
        end else if (go && !busy) begin
            busy <= 1'b1;
            tmr  <= '0;
        end else if (busy) begin
            busy <= !last;
            tmr  <= last ? '0 : tmr + 1'b1;
        end
    end

    // R2: the busy window ends only after the full count
    assert_busy_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(tmr) == TMR_W'(WRITE_CYCLES - 1)));

    // R3: a new commit request never lands on a running commit
    assert_go_idle_R3: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);

endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
    import page_commit_pkg::*;
#(
    parameter int PAGE_BYTES   = 64,
    parameter int ROW_W        = 9,
    parameter int WRITE_CYCLES = 500000,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_i,
    input  logic              start_evt_i,
    input  logic              stop_evt_i,
    input  logic              addr_hit_i,
    output logic              addr_ack_o,
    input  logic              byte_vld_i,
    input  logic [OFF_W-1:0]  byte_off_i,
    input  logic [DATA_W-1:0] byte_dat_i,
    input  logic [ROW_W-1:0]  byte_row_i,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic [ROW_W-1:0]  arr_row_o,
    output logic [OFF_W-1:0]  arr_off_o,
    output logic [DATA_W-1:0] arr_dat_o
);

    logic             busy, done, scan_act, pending, take, go, clr;
    logic [OFF_W-1:0] scan_off;
    logic [ROW_W-1:0] row_q;
    slot_t            rd_slot;
    stop_act_e        act;

    assign take = byte_vld_i && !busy;
    assign act  = stop_action(stop_evt_i, start_evt_i, busy, pending, wp_i);
    assign go   = (act == EV_COMMIT);
    assign clr  = done || (act == EV_DISCARD);

    always_ff @(posedge clk) begin
        if (rst)
            row_q <= '0;
        else if (take)
            row_q <= byte_row_i;
    end

    page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (take),
        .wr_off  (byte_off_i),
        .wr_dat  (byte_dat_i),
        .clr     (clr),
        .rd_off  (scan_off),
        .rd_slot (rd_slot),
        .any_vld (pending)
    );

    commit_seq #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .busy     (busy),
        .done     (done),
        .scan_act (scan_act),
        .scan_off (scan_off)
    );

    assign busy_o     = busy;
    assign addr_ack_o = addr_hit_i && !busy;
    assign arr_we_o   = scan_act && rd_slot.vld && !wp_i;
    assign arr_row_o  = row_q;
    assign arr_off_o  = scan_off;
    assign arr_dat_o  = rd_slot.dat;

    // R1: a commit begins only right after a STOP
    assert_rise_on_stop_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_evt_i));

    // R5: a protected STOP never starts a commit
    assert_no_commit_wp_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> !$past(wp_i));

    // R6: the target row is frozen for the whole commit
    assert_row_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(arr_row_o));

    // R6: array strobes stay inside the busy window
    assert_we_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
        arr_we_o |-> busy_o);

endmodule

// File: tb/page_commit_ctrl_bench.sv
`timescale 1ns/1ps
module page_commit_ctrl_bench;

    localparam int PB = 64;
    localparam int RW = 9;
    localparam int WC = 100;
    localparam int OW = $clog2(PB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wp_i = 1'b0, start_evt_i = 1'b0, stop_evt_i = 1'b0, addr_hit_i = 1'b0;
    logic          byte_vld_i = 1'b0;
    logic [OW-1:0] byte_off_i = '0;
    logic [7:0]    byte_dat_i = '0;
    logic [RW-1:0] byte_row_i = '0;
    logic          addr_ack_o, busy_o, arr_we_o;
    logic [RW-1:0] arr_row_o;
    logic [OW-1:0] arr_off_o;
    logic [7:0]    arr_dat_o;

    page_commit_ctrl #(.PAGE_BYTES(PB), .ROW_W(RW), .WRITE_CYCLES(WC)) u_page_commit_ctrl (
        .clk(clk), .rst(rst), .wp_i(wp_i), .start_evt_i(start_evt_i),
        .stop_evt_i(stop_evt_i), .addr_hit_i(addr_hit_i), .addr_ack_o(addr_ack_o),
        .byte_vld_i(byte_vld_i), .byte_off_i(byte_off_i), .byte_dat_i(byte_dat_i),
        .byte_row_i(byte_row_i), .busy_o(busy_o), .arr_we_o(arr_we_o),
        .arr_row_o(arr_row_o), .arr_off_o(arr_off_o), .arr_dat_o(arr_dat_o)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int busy_cnt = 0, we_cnt = 0, dup_cnt = 0, order_err = 0, late_we = 0, last_off = -1;
    logic [7:0]    exp_dat [PB];
    logic          exp_vld [PB];
    logic [7:0]    got_dat [PB];
    logic          got_vld [PB];
    logic [RW-1:0] exp_row, got_row;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
        if (busy_o) busy_cnt++;
        if (arr_we_o) begin
            if (got_vld[arr_off_o]) dup_cnt++;
            if (int'(arr_off_o) <= last_off) order_err++;
            if (busy_cnt > PB) late_we++;
            last_off = int'(arr_off_o);
            got_vld[arr_off_o] = 1'b1;
            got_dat[arr_off_o] = arr_dat_o;
            got_row = arr_row_o;
            we_cnt++;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_exp();
        for (int i = 0; i < PB; i++) begin
            exp_vld[i] = 1'b0; exp_dat[i] = '0;
            got_vld[i] = 1'b0; got_dat[i] = '0;
        end
        busy_cnt = 0; we_cnt = 0; dup_cnt = 0; order_err = 0; late_we = 0; last_off = -1;
    endtask

    task automatic send_byte(input int off, input logic [7:0] d, input logic [RW-1:0] row,
                             input bit model);
        byte_vld_i = 1'b1; byte_off_i = OW'(off); byte_dat_i = d; byte_row_i = row;
        tick();
        byte_vld_i = 1'b0;
        if (model) begin
            exp_vld[off] = 1'b1; exp_dat[off] = d; exp_row = row;
        end
        tick();
    endtask

    task automatic pulse_stop();
        stop_evt_i = 1'b1; tick(); stop_evt_i = 1'b0;
    endtask

    task automatic pulse_start();
        start_evt_i = 1'b1; tick(); start_evt_i = 1'b0;
    endtask

    function automatic int exp_count();
        int c = 0;
        for (int i = 0; i < PB; i++) if (exp_vld[i]) c++;
        return c;
    endfunction

    task automatic compare_page(input string req);
        int bad = 0;
        for (int i = 0; i < PB; i++)
            if (got_vld[i] !== exp_vld[i] || (exp_vld[i] && got_dat[i] !== exp_dat[i])) bad++;
        check(bad == 0, req, bad, 0);
        check(we_cnt == exp_count() && dup_cnt == 0 && order_err == 0 && late_we == 0,
              req, we_cnt, exp_count());
        if (we_cnt > 0) check(got_row == exp_row, req, got_row, exp_row);
    endtask

    task automatic commit_and_check(input bit poke);
        pulse_stop();
        check(busy_o == 1'b1, "R1", busy_o, 1);
        if (poke) begin
            tick(5);
            addr_hit_i = 1'b1; #1;
            check(addr_ack_o == 1'b0, "R3", addr_ack_o, 0);
            tick(); addr_hit_i = 1'b0;
            send_byte(($urandom % PB), 8'hEE, '1, 1'b0);
            pulse_start(); pulse_stop();
        end
        while (busy_o) tick();
        check(busy_cnt == WC, "R2", busy_cnt, WC);
        compare_page("R6");
        addr_hit_i = 1'b1; #1;
        check(addr_ack_o == 1'b1, "R4", addr_ack_o, 1);
        tick(); addr_hit_i = 1'b0;
    endtask

    task automatic expect_no_commit(input string req);
        busy_cnt = 0; we_cnt = 0;
        pulse_stop(); tick(3);
        check(busy_cnt == 0 && we_cnt == 0, req, busy_cnt + we_cnt, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        reset_exp();
        tick(4); rst = 1'b0; tick();
        check(busy_o == 1'b0 && arr_we_o == 1'b0, "R1", busy_o, 0);
        addr_hit_i = 1'b1; #1;
        check(addr_ack_o == 1'b1, "R4", addr_ack_o, 1);
        tick(); addr_hit_i = 1'b0;

        expect_no_commit("R1");

        reset_exp(); pulse_start();
        send_byte(5, 8'h15, 9'd3, 1'b1);
        send_byte(9, 8'h29, 9'd3, 1'b1);
        send_byte(63, 8'h3F, 9'd3, 1'b1);
        send_byte(0, 8'hA0, 9'd3, 1'b1);
        commit_and_check(1'b1);
        expect_no_commit("R8");
        expect_no_commit("R3");

        reset_exp(); pulse_start();
        send_byte(12, 8'h77, 9'd8, 1'b0);
        pulse_start();
        expect_no_commit("R7");

        reset_exp(); wp_i = 1'b1; pulse_start();
        send_byte(2, 8'h55, 9'd1, 1'b0);
        expect_no_commit("R5");
        wp_i = 1'b0;
        expect_no_commit("R5");

        for (int t = 0; t < 14; t++) begin
            int n, s;
            logic [RW-1:0] row;
            bit prot;
            reset_exp();
            n = 1 + ($urandom % 70);
            s = $urandom % PB;
            row = RW'($urandom);
            prot = (($urandom % 4) == 0);
            wp_i = prot;
            pulse_start();
            for (int k = 0; k < n; k++)
                send_byte((s + k) % PB, 8'($urandom), row, 1'b1);
            if (prot) begin
                expect_no_commit("R5");
                wp_i = 1'b0;
            end else begin
                commit_and_check(t % 2 == 0);
            end
            tick(2);
        end

        finish_run();
    end

endmodule